// File: doc/BRIEF.md
# Multicycle Integer Divider with Condition-Flag Rules

This block performs integer division for a processor core, one quotient bit per clock. It offers three forms: a word form that divides a 32-bit register by a 16-bit divisor and packs remainder and quotient into one register, a long form that divides 32 bits by 32 bits, and a wide form whose 64-bit dividend is built from two registers. Each form can be signed or unsigned. The core presents the register values, the divisor, the current condition flags and whether the quotient and remainder register indices match. It raises `start_i` for one cycle and, when `done_o` pulses, receives the values to write, per-register write enables, the new N, Z, V, C flags and a divide-by-zero indication.

Internally the operands are turned into magnitudes, divided by a restoring shift-subtract loop and given their signs back at the end. The quotient is negative when exactly one operand is negative, and the remainder takes the sign of the dividend. Overflow and zero-divisor cases leave the registers untouched. A compact-instruction-set mode limits the unit to 32/32 division and applies its own register write rule.

Top module: `div_flag_unit`

## Requirements
- R1: `form_i` selects the form: 0 is word, 2 is wide, and 1 or 3 is long. In word form, `quo_reg_i` is divided by `divisor_i[15:0]`. `quo_val_o` carries the remainder in bits 31:16 and the quotient in bits 15:0, with `wr_quo_o`=1 and `wr_rem_o`=0.
- R2: In long form, `quo_reg_i` is divided by `divisor_i`. The quotient is on `quo_val_o` and the remainder on `rem_val_o`. Both enables are set, except that when `same_idx_i`=1 only `wr_quo_o` is set.
- R3: In wide form the dividend is `{rem_reg_i, quo_reg_i}` (remainder register high). Writes follow the R2 rule.
- R4: When `signed_i`=1, operands are two's complement. The quotient truncates toward zero and a nonzero remainder has the sign of the dividend.
- R5: A zero divisor (`divisor_i[15:0]` in word form, the full value otherwise) sets `dz_o`=1, clears both write enables and returns `flags_o` equal to `flags_i`. The flag encoding is [3]=N, [2]=Z, [1]=V, [0]=C. `done_o` pulses one cycle after the start edge.
- R6: Overflow occurs when the quotient does not fit the result width (16 bits in word form, 32 otherwise), as an unsigned or a signed value. On overflow V=1, C=0, Z=0, N equals `flags_i[3]`, and both write enables are clear.
- R7: Without overflow, N is the quotient's top bit at the result width, Z is set when the quotient is zero at that width, and V=C=0.
- R8: With `compact_i`=1, `form_i` is ignored and a 32/32 division is done. When `same_idx_i`=1 only the quotient is written; otherwise only the remainder is written.
- R9: `done_o` is a one-cycle pulse. It comes 33 clock edges after the start edge for word and long forms and 65 for the wide form.
- R10: `start_i` is ignored while `busy_o`=1. All result outputs hold their values between `done_o` pulses.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a division (accepted when idle) |
| form_i | input | 2 | Form select: 0 word, 1/3 long, 2 wide |
| signed_i | input | 1 | Two's complement operands |
| compact_i | input | 1 | Compact mode: 32/32 only, alternate write rule |
| same_idx_i | input | 1 | Quotient and remainder registers are the same |
| quo_reg_i | input | 32 | Quotient/dividend register value |
| rem_reg_i | input | 32 | Remainder register value (high dividend in wide form) |
| divisor_i | input | 32 | Divisor |
| flags_i | input | 4 | Current flags {N,Z,V,C} |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | Result valid pulse |
| dz_o | output | 1 | Divide-by-zero exception |
| wr_quo_o | output | 1 | Write `quo_val_o` to the quotient register |
| wr_rem_o | output | 1 | Write `rem_val_o` to the remainder register |
| quo_val_o | output | 32 | Value for the quotient register |
| rem_val_o | output | 32 | Value for the remainder register |
| flags_o | output | 4 | New flags {N,Z,V,C} |

## Verification
A zero-divisor result is due one edge after the start edge. Every other result is due after 33 edges, or 65 in wide form. The bench computes that latency for each operation and samples at every falling edge in between. It requires `done_o` low on each of those cycles and high exactly on the due cycle, where it compares flags, write enables and the written values against its behavioural model. One cycle later it checks that the pulse has ended and the results have held. A start pulse injected mid-run must change neither the due cycle nor the result.

// File: rtl/div_pkg.sv
// Package: shared types for the multicycle divider.
// Assumes: the form encoding is fixed by the core's decoder (0 word, 2 wide, others long).
package div_pkg;

    typedef enum logic [1:0] {
        FORM_WORD = 2'd0,
        FORM_LONG = 2'd1,
        FORM_WIDE = 2'd2
    } div_form_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

endpackage

// File: rtl/div_prep.sv
// Module: div_prep
// Picks the effective form, builds the dividend and divisor magnitudes,
// records operand signs, flags a zero divisor and gives the iteration count.
// Assumes: DATA_W is even; purely combinational.
module div_prep
    import div_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]          form_i,
    input  logic                signed_i,
    input  logic                compact_i,
    input  logic [DATA_W-1:0]   quo_reg_i,
    input  logic [DATA_W-1:0]   rem_reg_i,
    input  logic [DATA_W-1:0]   divisor_i,
    output div_form_e           form_o,
    output logic [2*DATA_W-1:0] dvd_aligned_o,
    output logic [DATA_W-1:0]   dvs_mag_o,
    output logic                dvd_neg_o,
    output logic                dvs_neg_o,
    output logic                dvs_zero_o,
    output logic [$clog2(2*DATA_W+1)-1:0] iter_o
);
    localparam int WIDE_W = 2 * DATA_W;
    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(WIDE_W + 1);

    logic [WIDE_W-1:0] wide_raw;
    logic [DATA_W-1:0] narrow_mag;
    logic [HALF_W-1:0] half_dvs;
    logic [HALF_W-1:0] half_mag;

    // Resolve the form: compact mode forces the long form.
    always_comb begin
        if (compact_i) begin
            form_o = FORM_LONG;
        end else begin
            case (form_i)
                2'd0:    form_o = FORM_WORD;
                2'd2:    form_o = FORM_WIDE;
                default: form_o = FORM_LONG;
            endcase
        end
    end

    // Dividend magnitude, left-aligned so its top bit enters the loop first.
    always_comb begin
        wide_raw   = {rem_reg_i, quo_reg_i};
        narrow_mag = '0;
        if (form_o == FORM_WIDE) begin
            dvd_neg_o     = signed_i & rem_reg_i[DATA_W-1];
            dvd_aligned_o = dvd_neg_o ? (~wide_raw + WIDE_W'(1)) : wide_raw;
            iter_o        = CNT_W'(WIDE_W);
        end else begin
            dvd_neg_o     = signed_i & quo_reg_i[DATA_W-1];
            narrow_mag    = dvd_neg_o ? (~quo_reg_i + DATA_W'(1)) : quo_reg_i;
            dvd_aligned_o = {narrow_mag, {DATA_W{1'b0}}};
            iter_o        = CNT_W'(DATA_W);
        end
    end

    // Divisor magnitude: half width in word form, full width otherwise.
    always_comb begin
        half_dvs = divisor_i[HALF_W-1:0];
        half_mag = '0;
        if (form_o == FORM_WORD) begin
            dvs_neg_o  = signed_i & half_dvs[HALF_W-1];
            half_mag   = dvs_neg_o ? (~half_dvs + HALF_W'(1)) : half_dvs;
            dvs_mag_o  = {{HALF_W{1'b0}}, half_mag};
            dvs_zero_o = (half_dvs == '0);
        end else begin
            dvs_neg_o  = signed_i & divisor_i[DATA_W-1];
            dvs_mag_o  = dvs_neg_o ? (~divisor_i + DATA_W'(1)) : divisor_i;
            dvs_zero_o = (divisor_i == '0);
        end
    end

endmodule

// File: rtl/div_iter.sv
// Module: div_iter
// Restoring radix-2 shift-subtract engine on unsigned magnitudes.
// Each step shifts one dividend bit into the partial remainder and one
// quotient bit into the shift register.
// Assumes: dvs_i is nonzero while stepping; the partial remainder stays below it.
module div_iter #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                step_i,
    input  logic [2*DATA_W-1:0] dvd_i,
    input  logic [DATA_W-1:0]   dvs_i,
    output logic [2*DATA_W-1:0] quo_o,
    output logic [DATA_W-1:0]   rem_o
);
    localparam int WIDE_W = 2 * DATA_W;

    logic [WIDE_W-1:0] shift_q;
    logic [DATA_W-1:0] part_q;
    logic [DATA_W-1:0] dvs_q;
    logic [DATA_W:0]   trial;
    logic [DATA_W:0]   diff;
    logic              fits;

    // Trial subtraction of the divisor from the widened partial remainder.
    always_comb begin
        trial = {part_q, shift_q[WIDE_W-1]};
        diff  = trial - {1'b0, dvs_q};
        fits  = (trial >= {1'b0, dvs_q});
    end

    // Load operands, or advance one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            part_q  <= '0;
            dvs_q   <= '0;
        end else if (load_i) begin
            shift_q <= dvd_i;
            part_q  <= '0;
            dvs_q   <= dvs_i;
        end else if (step_i) begin
            shift_q <= {shift_q[WIDE_W-2:0], fits};
            part_q  <= fits ? diff[DATA_W-1:0] : trial[DATA_W-1:0];
        end
    end

    assign quo_o = shift_q;
    assign rem_o = part_q;

endmodule

// File: rtl/div_finish.sv
// Module: div_finish
// Restores signs, detects overflow at the result width, forms the flags
// and decides which registers are written.
// Assumes: magnitudes come from a completed division; combinational.
module div_finish
    import div_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  div_form_e           form_i,
    input  logic                signed_i,
    input  logic                compact_i,
    input  logic                same_idx_i,
    input  logic [3:0]          flags_i,
    input  logic                dvd_neg_i,
    input  logic                dvs_neg_i,
    input  logic                dz_i,
    input  logic [2*DATA_W-1:0] quo_mag_i,
    input  logic [DATA_W-1:0]   rem_mag_i,
    output logic [DATA_W-1:0]   quo_val_o,
    output logic [DATA_W-1:0]   rem_val_o,
    output logic                wr_quo_o,
    output logic                wr_rem_o,
    output logic [3:0]          flags_o
);
    localparam int WIDE_W = 2 * DATA_W;
    localparam int HALF_W = DATA_W / 2;

    logic              q_neg;
    logic [WIDE_W-1:0] quo_s;
    logic [DATA_W-1:0] rem_s;
    logic              hi_over_half, hi_over_full;
    logic [HALF_W-1:0] lo_half;
    logic [DATA_W-1:0] lo_full;
    logic              ovf_half, ovf_full, ovf;
    logic              n_res, z_res;

    // Apply result signs to the magnitudes.
    always_comb begin
        q_neg = dvd_neg_i ^ dvs_neg_i;
        quo_s = q_neg ? (~quo_mag_i + WIDE_W'(1)) : quo_mag_i;
        rem_s = dvd_neg_i ? (~rem_mag_i + DATA_W'(1)) : rem_mag_i;
    end

    // Overflow test on the magnitude against the signed or unsigned range.
    always_comb begin
        hi_over_half = |quo_mag_i[WIDE_W-1:HALF_W];
        hi_over_full = |quo_mag_i[WIDE_W-1:DATA_W];
        lo_half      = quo_mag_i[HALF_W-1:0];
        lo_full      = quo_mag_i[DATA_W-1:0];
        if (signed_i) begin
            ovf_half = hi_over_half | (q_neg ? (lo_half[HALF_W-1] & (|lo_half[HALF_W-2:0]))
                                             : lo_half[HALF_W-1]);
            ovf_full = hi_over_full | (q_neg ? (lo_full[DATA_W-1] & (|lo_full[DATA_W-2:0]))
                                             : lo_full[DATA_W-1]);
        end else begin
            ovf_half = hi_over_half;
            ovf_full = hi_over_full;
        end
        ovf = (form_i == FORM_WORD) ? ovf_half : ovf_full;
    end

    // Result values and quotient-derived N and Z.
    always_comb begin
        if (form_i == FORM_WORD) begin
            quo_val_o = {rem_s[HALF_W-1:0], quo_s[HALF_W-1:0]};
            n_res     = quo_s[HALF_W-1];
            z_res     = (quo_s[HALF_W-1:0] == '0);
        end else begin
            quo_val_o = quo_s[DATA_W-1:0];
            n_res     = quo_s[DATA_W-1];
            z_res     = (quo_s[DATA_W-1:0] == '0);
        end
        rem_val_o = rem_s;
    end

    // Write enables and flags by exception, overflow and mode.
    always_comb begin
        if (dz_i) begin
            wr_quo_o = 1'b0;
            wr_rem_o = 1'b0;
            flags_o  = flags_i;
        end else if (ovf) begin
            wr_quo_o = 1'b0;
            wr_rem_o = 1'b0;
            flags_o  = {flags_i[3], 1'b0, 1'b1, 1'b0};
        end else begin
            flags_o = {n_res, z_res, 1'b0, 1'b0};
            if (form_i == FORM_WORD) begin
                wr_quo_o = 1'b1;
                wr_rem_o = 1'b0;
            end else if (compact_i) begin
                wr_quo_o = same_idx_i;
                wr_rem_o = ~same_idx_i;
            end else begin
                wr_quo_o = 1'b1;
                wr_rem_o = ~same_idx_i;
            end
        end
    end

endmodule

// File: rtl/div_flag_unit.sv
// Module: div_flag_unit (top)
// Sequences a division: captures operands on start, runs one quotient bit
// per cycle, then registers values, enables, flags and the exception.
// Assumes: start_i is a single-cycle request; outputs hold until the next done.
module div_flag_unit
    import div_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        form_i,
    input  logic              signed_i,
    input  logic              compact_i,
    input  logic              same_idx_i,
    input  logic [DATA_W-1:0] quo_reg_i,
    input  logic [DATA_W-1:0] rem_reg_i,
    input  logic [DATA_W-1:0] divisor_i,
    input  logic [3:0]        flags_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              dz_o,
    output logic              wr_quo_o,
    output logic              wr_rem_o,
    output logic [DATA_W-1:0] quo_val_o,
    output logic [DATA_W-1:0] rem_val_o,
    output logic [3:0]        flags_o
);
    localparam int WIDE_W = 2 * DATA_W;
    localparam int CNT_W  = $clog2(WIDE_W + 1);

    div_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    div_form_e         form_q;
    logic              signed_q, compact_q, same_q, dvd_neg_q, dvs_neg_q, dz_q;
    logic [3:0]        flin_q;

    div_form_e         p_form;
    logic [WIDE_W-1:0] p_dvd;
    logic [DATA_W-1:0] p_dvs;
    logic              p_dvd_neg, p_dvs_neg, p_zero;
    logic [CNT_W-1:0]  p_iter;

    logic              load, step;
    logic [WIDE_W-1:0] quo_mag;
    logic [DATA_W-1:0] rem_mag;

    logic [DATA_W-1:0] f_quo, f_rem;
    logic              f_wq, f_wr;
    logic [3:0]        f_flags;

    div_prep #(.DATA_W(DATA_W)) u_prep (
        .form_i        (form_i),
        .signed_i      (signed_i),
        .compact_i     (compact_i),
        .quo_reg_i     (quo_reg_i),
        .rem_reg_i     (rem_reg_i),
        .divisor_i     (divisor_i),
        .form_o        (p_form),
        .dvd_aligned_o (p_dvd),
        .dvs_mag_o     (p_dvs),
        .dvd_neg_o     (p_dvd_neg),
        .dvs_neg_o     (p_dvs_neg),
        .dvs_zero_o    (p_zero),
        .iter_o        (p_iter)
    );

    assign load = (state_q == ST_IDLE) && start_i;
    assign step = (state_q == ST_RUN);

    div_iter #(.DATA_W(DATA_W)) u_iter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step),
        .dvd_i  (p_dvd),
        .dvs_i  (p_dvs),
        .quo_o  (quo_mag),
        .rem_o  (rem_mag)
    );

    div_finish #(.DATA_W(DATA_W)) u_fin (
        .form_i     (form_q),
        .signed_i   (signed_q),
        .compact_i  (compact_q),
        .same_idx_i (same_q),
        .flags_i    (flin_q),
        .dvd_neg_i  (dvd_neg_q),
        .dvs_neg_i  (dvs_neg_q),
        .dz_i       (dz_q),
        .quo_mag_i  (quo_mag),
        .rem_mag_i  (rem_mag),
        .quo_val_o  (f_quo),
        .rem_val_o  (f_rem),
        .wr_quo_o   (f_wq),
        .wr_rem_o   (f_wr),
        .flags_o    (f_flags)
    );

    // Sequencer: capture context on start, count steps, then finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            form_q    <= FORM_WORD;
            signed_q  <= 1'b0;
            compact_q <= 1'b0;
            same_q    <= 1'b0;
            dvd_neg_q <= 1'b0;
            dvs_neg_q <= 1'b0;
            dz_q      <= 1'b0;
            flin_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        form_q    <= p_form;
                        signed_q  <= signed_i;
                        compact_q <= compact_i;
                        same_q    <= same_idx_i;
                        dvd_neg_q <= p_dvd_neg;
                        dvs_neg_q <= p_dvs_neg;
                        dz_q      <= p_zero;
                        flin_q    <= flags_i;
                        cnt_q     <= p_iter;
                        state_q   <= p_zero ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1)) begin
                        state_q <= ST_FIN;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Result registers: loaded only in the finish state, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            dz_o      <= 1'b0;
            wr_quo_o  <= 1'b0;
            wr_rem_o  <= 1'b0;
            quo_val_o <= '0;
            rem_val_o <= '0;
            flags_o   <= '0;
        end else begin
            done_o <= (state_q == ST_FIN);
            if (state_q == ST_FIN) begin
                dz_o      <= dz_q;
                wr_quo_o  <= f_wq;
                wr_rem_o  <= f_wr;
                quo_val_o <= f_quo;
                rem_val_o <= f_rem;
                flags_o   <= f_flags;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/div_flag_unit_chk.sv
// Module: div_flag_unit_chk
// Port-level properties of the divider, bound to every div_flag_unit instance.
// Assumes: reset is held for at least two clock edges.
module div_flag_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              dz_o,
    input logic              wr_quo_o,
    input logic              wr_rem_o,
    input logic [DATA_W-1:0] quo_val_o,
    input logic [DATA_W-1:0] rem_val_o,
    input logic [3:0]        flags_o
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dz_o) |-> (!wr_quo_o && !wr_rem_o));

    // R6
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dz_o && flags_o[1]) |-> (!wr_quo_o && !wr_rem_o && !flags_o[2] && !flags_o[0]));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dz_o && !flags_o[1]) |-> (!flags_o[0] && (wr_quo_o || wr_rem_o)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quo_val_o) && $stable(rem_val_o) && $stable(flags_o)
                     && $stable(wr_quo_o) && $stable(wr_rem_o) && $stable(dz_o)));

    // R10
    idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

bind div_flag_unit div_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .dz_o      (dz_o),
    .wr_quo_o  (wr_quo_o),
    .wr_rem_o  (wr_rem_o),
    .quo_val_o (quo_val_o),
    .rem_val_o (rem_val_o),
    .flags_o   (flags_o)
);

// File: tb/sim_div_flag_unit.sv
`timescale 1ns/1ps
module sim_div_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  form_i = '0;
    logic        signed_i = 1'b0, compact_i = 1'b0, same_idx_i = 1'b0;
    logic [31:0] quo_reg_i = '0, rem_reg_i = '0, divisor_i = '0;
    logic [3:0]  flags_i = '0;
    logic        busy_o, done_o, dz_o, wr_quo_o, wr_rem_o;
    logic [31:0] quo_val_o, rem_val_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    div_flag_unit #(.DATA_W(32)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural model plus cycle-by-cycle comparison for one operation.
    task automatic run_op(input logic [1:0] fm, input bit sg, input bit cp, input bit sm,
                          input logic [31:0] qr, input logic [31:0] rr, input logic [31:0] dv,
                          input logic [3:0] fl, input bit interfere, input string tag);
        int eff, lat;
        bit dn, sn, qn, ovf, ez, ewq, ewr;
        logic [63:0] dm, vm, qm, rm, qs, rs;
        logic [31:0] eq;
        logic [3:0]  ef;
        eff = cp ? 1 : (fm == 2'd0 ? 0 : (fm == 2'd2 ? 2 : 1));
        if (eff == 2) begin
            dn = sg & rr[31];
            dm = dn ? (64'd0 - {rr, qr}) : {rr, qr};
        end else begin
            dn = sg & qr[31];
            dm = dn ? {32'd0, 32'd0 - qr} : {32'd0, qr};
        end
        if (eff == 0) begin
            sn = sg & dv[15];
            vm = sn ? {48'd0, 16'd0 - dv[15:0]} : {48'd0, dv[15:0]};
        end else begin
            sn = sg & dv[31];
            vm = sn ? {32'd0, 32'd0 - dv} : {32'd0, dv};
        end
        ez = (vm == 64'd0);
        qm = ez ? 64'd0 : dm / vm;
        rm = ez ? 64'd0 : dm % vm;
        qn = dn ^ sn;
        qs = qn ? 64'd0 - qm : qm;
        rs = dn ? 64'd0 - rm : rm;
        if (eff == 0) ovf = sg ? (qn ? qm > 64'h8000 : qm > 64'h7FFF) : qm > 64'hFFFF;
        else          ovf = sg ? (qn ? qm > 64'h8000_0000 : qm > 64'h7FFF_FFFF) : qm > 64'hFFFF_FFFF;
        if (ez) begin
            ef = fl; ewq = 0; ewr = 0;
        end else if (ovf) begin
            ef = {fl[3], 3'b010}; ewq = 0; ewr = 0;
        end else begin
            if (eff == 0) ef = {qs[15], qs[15:0] == 16'd0, 2'b00};
            else          ef = {qs[31], qs[31:0] == 32'd0, 2'b00};
            if (eff == 0)  begin ewq = 1; ewr = 0; end
            else if (cp)   begin ewq = sm; ewr = !sm; end
            else           begin ewq = 1; ewr = !sm; end
        end
        eq  = (eff == 0) ? {rs[15:0], qs[15:0]} : qs[31:0];
        lat = ez ? 1 : ((eff == 2) ? 64 : 32) + 1;

        @(negedge clk);
        form_i = fm; signed_i = sg; compact_i = cp; same_idx_i = sm;
        quo_reg_i = qr; rem_reg_i = rr; divisor_i = dv; flags_i = fl;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= lat; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k < lat) begin
                chk(done_o == 1'b0, {"R9 early done ", tag}, 64'(done_o), 64'd0);
                if (interfere && k == 4) begin
                    start_i = 1'b1; quo_reg_i = 32'h1234_5678; divisor_i = 32'd3; form_i = 2'd2;
                end
                if (interfere && k == 5) start_i = 1'b0;
            end else begin
                chk(done_o == 1'b1, {"R9 done due ", tag}, 64'(done_o), 64'd1);
                chk(dz_o == ez, {"R5 dz ", tag}, 64'(dz_o), 64'(ez));
                chk(flags_o == ef, {"R6/R7 flags ", tag}, 64'(flags_o), 64'(ef));
                chk(wr_quo_o == ewq, {"R2/R8 wr_quo ", tag}, 64'(wr_quo_o), 64'(ewq));
                chk(wr_rem_o == ewr, {"R2/R8 wr_rem ", tag}, 64'(wr_rem_o), 64'(ewr));
                if (ewq) chk(quo_val_o == eq, {"R1/R4 quo_val ", tag}, 64'(quo_val_o), 64'(eq));
                if (ewr) chk(rem_val_o == rs[31:0], {"R3/R4 rem_val ", tag}, 64'(rem_val_o), rs);
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b0, {"R9 pulse width ", tag}, 64'(done_o), 64'd0);
        chk(flags_o == ef && wr_quo_o == ewq && wr_rem_o == ewr, {"R10 hold ", tag},
            64'({flags_o, wr_quo_o, wr_rem_o}), 64'({ef, ewq, ewr}));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk(!busy_o && !done_o && !dz_o && !wr_quo_o && !wr_rem_o && quo_val_o == 0
            && rem_val_o == 0 && flags_o == 0, "R11 reset",
            64'({busy_o, done_o, dz_o, wr_quo_o, wr_rem_o, flags_o}), 64'd0);
        // R1 word unsigned, R7 flags
        run_op(2'd0, 0, 0, 0, 32'd100000, 32'd0, 32'd7, 4'b0000, 0, "R1 word unsigned");
        run_op(2'd0, 0, 0, 0, 32'd5, 32'd0, 32'hFFFF_0007, 4'b1111, 0, "R7 zero quotient");
        // R6 word overflow, N preserved
        run_op(2'd0, 0, 0, 0, 32'h0010_0000, 32'd0, 32'd1, 4'b1001, 0, "R6 word unsigned ovf");
        // R4 word signed
        run_op(2'd0, 1, 0, 0, -32'sd100, 32'd0, 32'd7, 4'b0000, 0, "R4 word signed");
        run_op(2'd0, 1, 0, 0, 32'd32768, 32'd0, 32'h0000_FFFF, 4'b0000, 0, "R6 word signed edge");
        run_op(2'd0, 1, 0, 0, -32'sd32768, 32'd0, 32'h0000_FFFF, 4'b0000, 0, "R6 word signed ovf");
        // R5 zero divisor (word form uses low half only) and long form
        run_op(2'd0, 0, 0, 0, 32'd77, 32'd0, 32'h0005_0000, 4'b1010, 0, "R5 word zero");
        run_op(2'd1, 1, 0, 0, 32'd77, 32'd0, 32'd0, 4'b0101, 0, "R5 long zero");
        // R2 long unsigned, same-index and signed
        run_op(2'd1, 0, 0, 0, 32'hFFFF_FFFF, 32'd0, 32'd3, 4'b0000, 0, "R2 long unsigned");
        run_op(2'd3, 0, 0, 1, 32'd1000, 32'd0, 32'd33, 4'b0000, 0, "R2 long same idx");
        run_op(2'd1, 1, 0, 0, -32'sd1001, 32'd0, -32'sd10, 4'b0000, 0, "R4 long signed");
        run_op(2'd1, 1, 0, 0, 32'h8000_0000, 32'd0, 32'hFFFF_FFFF, 4'b1000, 0, "R6 long signed ovf");
        // R3 wide form
        run_op(2'd2, 0, 0, 0, 32'd0, 32'd1, 32'd2, 4'b0000, 0, "R3 wide unsigned");
        run_op(2'd2, 0, 0, 0, 32'd0, 32'd2, 32'd2, 4'b0000, 0, "R6 wide ovf");
        run_op(2'd2, 1, 0, 0, 32'h0000_0005, 32'hFFFF_FFFF, 32'd3, 4'b0000, 0, "R3 wide signed");
        // R8 compact mode
        run_op(2'd2, 0, 1, 0, 32'd1000, 32'd9, 32'd7, 4'b0000, 0, "R8 compact diff idx");
        run_op(2'd0, 1, 1, 1, -32'sd70000, 32'd9, 32'd7, 4'b0000, 0, "R8 compact same idx");
        // R10 start while busy is ignored
        run_op(2'd1, 0, 0, 0, 32'd999, 32'd0, 32'd10, 4'b0000, 1, "R10 busy start");
        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule